// File: doc/BRIEF.md
# Nibble-RAM bank controller

This block sits between a CPU address bus and an external ROM model. It gives the CPU a window of ROM that never moves and a second window whose bank can be switched. It also holds a small on-chip scratch RAM of 512 entries that are 4 bits wide. The ROM can have from 2 to 16 banks of 16 KiB each.

Two control registers steer the block: a RAM-enable flag and a ROM bank select. The CPU sets both by writing into the low ROM half of the address map. Address bit 8 of such a write decides which register it may touch. The RAM keeps only the low nibble of each byte written to it. On a read the upper nibble comes back as all ones.

ROM reads pass straight through: the block forms the ROM address and returns the external ROM byte on the CPU read data. Reads of an address that maps to nothing, and reads of the RAM while it is disabled, return 0xFF.

Top module: `nram_bank_ctl`

## Requirements
- R1: After reset the RAM is disabled and the switched window maps to bank 1.
- R2: A write to 0x0000-0x1FFF with address bit 8 = 0 sets the RAM enable when data[3:0] = 0xA and clears it for any other value, including 0x00.
- R3: A write to 0x0000-0x1FFF with address bit 8 = 1 leaves the RAM enable unchanged.
- R4: A write to 0x2000-0x3FFF with address bit 8 = 1 loads the bank select. The new value is data[3:0] ANDed with (ROM_BANKS-1), and a result of 0 is replaced by 1. Data bits [7:4] are ignored.
- R5: A write to 0x2000-0x3FFF with address bit 8 = 0 leaves the bank select unchanged.
- R6: For an address in 0x0000-0x3FFF, rom_addr = {0, addr[13:0]}. For an address in 0x4000-0x7FFF, rom_addr = {bank, addr[13:0]}. A read of either range returns rom_data.
- R7: While the RAM is enabled, a write to 0xA000-0xA1FF stores data[3:0] at entry addr[8:0]. A read of that range returns {4'hF, stored nibble}.
- R8: While the RAM is disabled, reads of 0xA000-0xA1FF return 0xFF and writes there leave the stored contents unchanged.
- R9: Addresses 0xA200-0xBFFF are out of range. Reads there return 0xFF, and writes there change no RAM entry.
- R10: Reads of 0x8000-0x9FFF and 0xC000-0xFFFF return 0xFF, and cpu_rdata is 0xFF whenever cpu_rd is low. Writes to 0x4000-0x7FFF change neither control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cpu_rdata | output | 8 | Read data, combinational from address and state |
| rom_addr | output | $clog2(ROM_BANKS)+14 | Address to the external ROM |
| rom_data | input | 8 | Byte returned by the external ROM |

## Verification
A wrong bank select shows up at once on rom_addr bits [ROM_AW-1:14] for any address in the switched window, so every bank write is followed by a probe of 0x4000-0x7FFF in the next cycle. A wrong enable flag shows on the first RAM read that follows, either as a 0xFF where data was expected or as data where 0xFF was expected. Address decode faults such as aliasing of the out-of-range area, a lost bit-8 steer or a write that lands while the RAM is off stay hidden until the affected entry or register is read back. For that reason the bench reads back the exact entries and registers such a write could have touched.

// File: rtl/nram_pkg.sv
package nram_pkg;

  typedef enum logic [2:0] {
    RG_ROM_FIXED,
    RG_ROM_SWITCH,
    RG_RAM,
    RG_RAM_OOR,
    RG_NONE
  } region_e;

  // Map a CPU address to the area it belongs to.
  function automatic region_e classify(input logic [15:0] a);
    region_e r;
    if (a[15] == 1'b0)
      r = a[14] ? RG_ROM_SWITCH : RG_ROM_FIXED;
    else if (a[15:13] == 3'b101)
      r = (a[12:9] == 4'b0000) ? RG_RAM : RG_RAM_OOR;
    else
      r = RG_NONE;
    return r;
  endfunction

  // Control space: 0x0000-0x1FFF is enable, 0x2000-0x3FFF is bank.
  function automatic logic in_enable_space(input logic [15:0] a);
    return a[15:13] == 3'b000;
  endfunction

  function automatic logic in_bank_space(input logic [15:0] a);
    return a[15:13] == 3'b001;
  endfunction

  // Only the low nibble matters; the value 0xA turns the RAM on.
  function automatic logic enable_value(input logic [3:0] nib);
    return nib == 4'hA;
  endfunction

  // Mask to the ROM size, then replace bank 0 with bank 1.
  function automatic logic [3:0] pick_bank(input logic [3:0] nib,
                                           input logic [3:0] mask);
    logic [3:0] sel;
    sel = nib & mask;
    if (sel == 4'h0) sel = 4'h1;
    return sel;
  endfunction

endpackage

// File: rtl/nram_ctrl_regs.sv
module nram_ctrl_regs #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [15:0]       addr,
  input  logic [3:0]        wnib,
  output logic              ram_en,
  output logic [BANK_W-1:0] bank
);
  import nram_pkg::*;

  localparam logic [3:0] MASK = 4'((1 << BANK_W) - 1);
  localparam logic [BANK_W-1:0] BANK_RST = BANK_W'(1);

  // Write events, named so the checks below can refer to them
  logic en_wr_evt;
  logic bank_wr_evt;

  assign en_wr_evt   = wr && in_enable_space(addr) && !addr[8];
  assign bank_wr_evt = wr && in_bank_space(addr) && addr[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en <= 1'b0;
      bank   <= BANK_RST;
    end else begin
      if (en_wr_evt)   ram_en <= enable_value(wnib);
      if (bank_wr_evt) bank   <= BANK_W'(pick_bank(wnib, MASK));
    end
  end

  // R4
  bank_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank != '0);

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_enable_space(addr) && addr[8]) |=> $stable(ram_en));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_bank_space(addr) && !addr[8]) |=> $stable(bank));

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_evt && wnib == 4'hA) |=> ram_en);

endmodule

// File: rtl/nram_rom_map.sv
module nram_rom_map #(
  parameter int BANK_W = 4,
  localparam int ROM_AW = BANK_W + 14
) (
  input  logic [14:0]       addr,
  input  logic [BANK_W-1:0] bank,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [BANK_W-1:0] win_bank;

  // The fixed window always points at bank 0
  assign win_bank = addr[14] ? bank : '0;
  assign rom_addr = {win_bank, addr[13:0]};

endmodule

// File: rtl/nram_store.sv
module nram_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdat,
  output logic [DW-1:0] rdat
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdat;
  end

  assign rdat = mem[idx];

endmodule

// File: rtl/nram_bank_ctl.sv
module nram_bank_ctl #(
  parameter int ROM_BANKS = 16,
  localparam int BANK_W   = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int ROM_AW   = BANK_W + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data
);
  import nram_pkg::*;

  localparam int RAM_DEPTH = 512;
  localparam int RAM_DW    = 4;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  generate
    if (ROM_BANKS < 2 || ROM_BANKS > 16) begin : g_bad_size
      $error("ROM_BANKS must lie in 2..16");
    end
  endgenerate

  region_e           region;
  logic              ram_en;
  logic [BANK_W-1:0] bank;
  logic [RAM_DW-1:0] ram_nib;
  logic              ram_wr_evt;
  logic [7:0]        sel_data;

  assign region     = classify(cpu_addr);
  assign ram_wr_evt = cpu_wr && ram_en && (region == RG_RAM);

  nram_ctrl_regs #(.BANK_W(BANK_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cpu_wr),
    .addr   (cpu_addr),
    .wnib   (cpu_wdata[3:0]),
    .ram_en (ram_en),
    .bank   (bank)
  );

  nram_rom_map #(.BANK_W(BANK_W)) u_map (
    .addr     (cpu_addr[14:0]),
    .bank     (bank),
    .rom_addr (rom_addr)
  );

  nram_store #(.DEPTH(RAM_DEPTH), .DW(RAM_DW)) u_store (
    .clk  (clk),
    .we   (ram_wr_evt),
    .idx  (cpu_addr[RAM_AW-1:0]),
    .wdat (cpu_wdata[RAM_DW-1:0]),
    .rdat (ram_nib)
  );

  always_comb begin
    unique case (region)
      RG_ROM_FIXED, RG_ROM_SWITCH: sel_data = rom_data;
      RG_RAM:  sel_data = ram_en ? {4'hF, ram_nib} : 8'hFF;
      default: sel_data = 8'hFF;
    endcase
  end

  assign cpu_rdata = cpu_rd ? sel_data : 8'hFF;

  // R6
  fixed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_AW-1:14] == '0);

  // R6
  sw_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> rom_addr[ROM_AW-1:14] != '0);

  // R7
  ram_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && region == RG_RAM) |-> cpu_rdata[7:4] == 4'hF);

  // R9
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && (region == RG_RAM_OOR || region == RG_NONE)) |-> cpu_rdata == 8'hFF);

  // R10
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:14] == 2'b01) |=> ($stable(bank) && $stable(ram_en)));

endmodule

// File: tb/nram_bank_ctl_bench.sv
module nram_bank_ctl_bench;
  localparam int NB = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   cpu_addr;
  logic [7:0]    cpu_wdata;
  logic          cpu_rd;
  logic          cpu_wr;
  logic [7:0]    cpu_rdata;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  assign rom_data = rom_addr[7:0] ^ rom_addr[15:8];

  nram_bank_ctl #(.ROM_BANKS(NB)) u_nram_bank_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_data(rom_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    check(cpu_rdata == exp, req, cpu_rdata, exp);
    cpu_rd = 1'b0;
  endtask

  // Expected ROM address for a read in 0x0000-0x7FFF given the bank select
  task automatic rom_chk(input logic [15:0] a, input int bnk, input string req);
    logic [AW-1:0] exp;
    exp = {(a[14] ? 2'(bnk) : 2'b00), a[13:0]};
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    check(rom_addr == exp, req, rom_addr, exp);
    check(cpu_rdata == (exp[7:0] ^ exp[15:8]), req, cpu_rdata, exp[7:0] ^ exp[15:8]);
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(16'hA000, 8'hFF, "R1 ram off");
    rom_chk(16'h4123, 1, "R1 bank one");
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_rd = 1'b0;
    #1;
    check(cpu_rdata == 8'hFF, "R10 rd low", cpu_rdata, 8'hFF);
  endtask

  task automatic t_enable;
    wr(16'h0100, 8'h0A);
    rd_chk(16'hA000, 8'hFF, "R3 bit8 set ignored");
    wr(16'h0000, 8'h0A);
    wr(16'hA000, 8'h5C);
    rd_chk(16'hA000, 8'hFC, "R2 enable");
    wr(16'h1E00, 8'h00);
    rd_chk(16'hA000, 8'hFF, "R2 disable");
    wr(16'h1F00, 8'h0A);
    rd_chk(16'hA000, 8'hFF, "R3 high alias ignored");
    wr(16'h1E55, 8'h1A);
    rd_chk(16'hA000, 8'hFC, "R2 nibble A enables");
    wr(16'h0000, 8'h05);
    rd_chk(16'hA000, 8'hFF, "R2 other disables");
  endtask

  task automatic t_bank;
    wr(16'h2100, 8'h03);
    rom_chk(16'h4000, 3, "R4 load");
    wr(16'h2000, 8'h02);
    rom_chk(16'h5ABC, 3, "R5 bit8 clear ignored");
    wr(16'h3F00, 8'h06);
    rom_chk(16'h7FFF, 2, "R4 mask");
    wr(16'h2100, 8'h00);
    rom_chk(16'h4001, 1, "R4 zero remap");
    wr(16'h2100, 8'h04);
    rom_chk(16'h4002, 1, "R4 mask then remap");
    wr(16'h2100, 8'hF3);
    rom_chk(16'h6000, 3, "R4 upper bits ignored");
    rom_chk(16'h3ABC, 3, "R6 fixed window");
    rom_chk(16'h0000, 3, "R6 fixed low");
  endtask

  task automatic t_ram;
    wr(16'h0000, 8'h0A);
    wr(16'hA000, 8'h3B);
    wr(16'hA1FF, 8'h07);
    wr(16'hA0AA, 8'hF0);
    rd_chk(16'hA000, 8'hFB, "R7 entry 0");
    rd_chk(16'hA1FF, 8'hF7, "R7 last entry");
    rd_chk(16'hA0AA, 8'hF0, "R7 mid entry");
  endtask

  task automatic t_disabled;
    wr(16'h0000, 8'h00);
    wr(16'hA000, 8'h01);
    rd_chk(16'hA1FF, 8'hFF, "R8 read off");
    wr(16'h0000, 8'h0A);
    rd_chk(16'hA000, 8'hFB, "R8 write off kept");
  endtask

  task automatic t_out_of_range;
    wr(16'hA200, 8'h09);
    wr(16'hBFFF, 8'h02);
    rd_chk(16'hA000, 8'hFB, "R9 no alias low");
    rd_chk(16'hA1FF, 8'hF7, "R9 no alias high");
    rd_chk(16'hA200, 8'hFF, "R9 read A200");
    rd_chk(16'hBFFF, 8'hFF, "R9 read BFFF");
    rd_chk(16'h8000, 8'hFF, "R10 read 8000");
    rd_chk(16'hC000, 8'hFF, "R10 read C000");
    rd_chk(16'hFFFF, 8'hFF, "R10 read FFFF");
    wr(16'h4100, 8'h00);
    wr(16'h6000, 8'h02);
    rom_chk(16'h4000, 3, "R10 bank untouched");
    rd_chk(16'hA0AA, 8'hF0, "R10 enable untouched");
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_bank();
    t_ram();
    t_disabled();
    t_out_of_range();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule